// File: doc/BRIEF.md
# Dual-Edge Event Counter with Overflow Interrupt

This block is a small event counter. It is meant to sit beside a serial shift stage, but it can also work on its own. It advances from one of three sources. The first is an external clock pin, on which every transition counts, rising or falling. The second is an overflow tick from a neighbouring 8-bit timer. The third is a software strobe, which advances the counter whatever source is selected. When the count wraps from all ones to zero, a sticky overflow flag is set. An interrupt-enable bit gates that flag onto the interrupt output.

The counter drives a one-cycle carry pulse on each wrap. A downstream 8-bit stage can use this pulse as its count enable, which forms a 12-bit counter read as {upper byte, this nibble}. A register load presets the count. Preloading all ones turns the block into an extra edge-triggered interrupt: the next single pin transition overflows the counter and raises the interrupt. A software strobe used the same way gives a software interrupt.

Top module: `sclk_edge_counter`

## Requirements
- R1: After reset, count is 0, ovf_flag is 0, irq is 0, carry is 0, and the interrupt enable is cleared.
- R2: With src_sel = 2'b10 (pin source), every rising and every falling transition of ext_clk_pin adds one to count. The new value is visible after the third rising clk edge that follows the pin change, and not after the second. The pin must hold each level for at least two clk cycles.
- R3: With src_sel = 2'b01 (timer source), each clk cycle in which timer_tick is high adds one to count at the next rising edge.
- R4: Each cycle in which strobe is high adds exactly one to count, whatever src_sel is. A strobe that coincides with a source event still adds only one.
- R5: Inputs that are not selected have no effect on count. With src_sel = 2'b00 or 2'b11, neither timer_tick nor the pin advances the counter. With src_sel = 2'b01, the pin is ignored.
- R6: An increment from 4'hF gives count 0, sets ovf_flag, and raises carry for exactly the one cycle in which count first reads 0 after the wrap.
- R7: ovf_flag stays set until a cycle with flag_clr = 1 clears it. If a wrap and flag_clr happen in the same cycle, the flag is set.
- R8: irq is high exactly when ovf_flag and the interrupt enable are both set. The enable takes ie_val in a cycle with ie_wr = 1.
- R9: In a cycle with load_en = 1, count takes load_val at the next edge. Any increment in that cycle is dropped, and it causes no overflow and no carry.
- R10: After count is loaded with 4'hF in pin mode, a single pin transition wraps the counter. This sets ovf_flag and, with the enable set, raises irq.
- R11: An 8-bit stage enabled by carry, together with count, holds the total number of increments as the 12-bit value {upper, count}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_pin | input | 1 | Asynchronous external count pin, both edges counted |
| strobe | input | 1 | Software count strobe, one cycle per increment |
| timer_tick | input | 1 | Overflow tick from an 8-bit timer |
| src_sel | input | 2 | Source: 00 none, 01 timer, 10 pin, 11 none |
| load_en | input | 1 | Load count from load_val |
| load_val | input | CNT_W | Preset value for count |
| ie_wr | input | 1 | Write strobe for the interrupt enable |
| ie_val | input | 1 | New interrupt-enable value |
| flag_clr | input | 1 | Write one to clear the overflow flag |
| count | output | CNT_W | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request, flag gated by enable |
| carry | output | 1 | One-cycle pulse on each wrap |

## Verification
The hardest situations to reach are the cycle collisions: a wrap that lands in the same cycle as a flag clear, a load that lands on a strobe, and a strobe that lands on a timer tick. The stimulus first preloads the counter to 4'hE or 4'hF. One more event then makes the collision cycle fall on a known edge. The pin path is checked with its three-cycle synchronizer latency. The bench samples once before the expected edge and once after it. It does this for both pin polarities, so that a lost edge or a one-cycle latency error shows up.

// File: rtl/sec_pkg.sv
package sec_pkg;
   typedef enum logic [1:0] {
      SRC_OFF   = 2'b00,
      SRC_TIMER = 2'b01,
      SRC_PIN   = 2'b10,
      SRC_RSVD  = 2'b11
   } src_e;
endpackage

// File: rtl/sec_pin_sync.sv
// Synchronizes the asynchronous pin and flags any transition (both polarities).
module sec_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic edge_o
);
   localparam int LAST = STAGES;

   // chain[0..STAGES-1]: synchronizer, chain[STAGES]: previous synchronized sample
   logic [LAST:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sec_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[LAST-1:0], pin_i};
   end

   assign edge_o = chain[LAST-1] ^ chain[LAST];
endmodule

// File: rtl/sec_src_sel.sv
// Turns the selected count source and the software strobe into one advance request.
module sec_src_sel
   import sec_pkg::*;
#(
   parameter bit TIMER_SRC_EN = 1'b1
) (
   input  logic [1:0] src_sel,
   input  logic       pin_edge,
   input  logic       timer_tick,
   input  logic       strobe,
   output logic       adv
);
   src_e src;
   logic timer_ev;
   logic pin_ev;

   assign src    = src_e'(src_sel);
   assign pin_ev = (src == SRC_PIN) && pin_edge;

   generate
      if (TIMER_SRC_EN) begin : g_timer
         assign timer_ev = (src == SRC_TIMER) && timer_tick;
      end else begin : g_no_timer
         assign timer_ev = 1'b0;
      end
   endgenerate

   // Coincident requests merge into a single step.
   assign adv = strobe | pin_ev | timer_ev;
endmodule

// File: rtl/sec_count_core.sv
// Counter register, wrap detection, sticky flag and interrupt enable.
module sec_count_core #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         flag_clr,
   input  logic         ie_wr,
   input  logic         ie_val,
   output logic [W-1:0] cnt,
   output logic         flag,
   output logic         ie,
   output logic         carry
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
   localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

   logic wrap;

   assign wrap = adv && !load_en && (cnt == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         flag  <= 1'b0;
         ie    <= 1'b0;
         carry <= 1'b0;
      end else begin
         if (load_en)  cnt <= load_val;
         else if (adv) cnt <= cnt + CNT_ONE;
         carry <= wrap;
         if (wrap)          flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         if (ie_wr) ie <= ie_val;
      end
   end
endmodule

// File: rtl/sclk_edge_counter.sv
module sclk_edge_counter #(
   parameter int CNT_W        = 4,
   parameter int SYNC_STAGES  = 2,
   parameter bit TIMER_SRC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk_pin,
   input  logic             strobe,
   input  logic             timer_tick,
   input  logic [1:0]       src_sel,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             ie_wr,
   input  logic             ie_val,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             irq,
   output logic             carry
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("sclk_edge_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic pin_edge;
   logic adv;
   logic ie;

   sec_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_clk_pin),
      .edge_o (pin_edge)
   );

   sec_src_sel #(.TIMER_SRC_EN(TIMER_SRC_EN)) u_sel (
      .src_sel    (src_sel),
      .pin_edge   (pin_edge),
      .timer_tick (timer_tick),
      .strobe     (strobe),
      .adv        (adv)
   );

   sec_count_core #(.W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .load_en  (load_en),
      .load_val (load_val),
      .flag_clr (flag_clr),
      .ie_wr    (ie_wr),
      .ie_val   (ie_val),
      .cnt      (count),
      .flag     (ovf_flag),
      .ie       (ie),
      .carry    (carry)
   );

   assign irq = ovf_flag & ie;
endmodule

// File: rtl/sec_checker.sv
module sec_checker #(
   parameter int W = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] cnt,
   input logic         load_en,
   input logic [W-1:0] load_val,
   input logic         flag,
   input logic         flag_clr,
   input logic         irq,
   input logic         carry
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (cnt == $past(load_val)));

   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE));

   assert_carry_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      carry |-> (cnt == '0 && $past(cnt) == MAXV));

   assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !$past(flag)) |-> carry);

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
endmodule

bind sclk_edge_counter sec_checker #(.W(CNT_W)) u_sec_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt      (count),
   .load_en  (load_en),
   .load_val (load_val),
   .flag     (ovf_flag),
   .flag_clr (flag_clr),
   .irq      (irq),
   .carry    (carry)
);

// File: tb/sclk_edge_counter_test.sv
module sclk_edge_counter_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ext_clk_pin, strobe, timer_tick;
   logic [1:0] src_sel;
   logic       load_en;
   logic [3:0] load_val;
   logic       ie_wr, ie_val, flag_clr;
   logic [3:0] count;
   logic       ovf_flag, irq, carry;

   always #2 clk = ~clk;

   sclk_edge_counter uut (
      .clk(clk), .rst_n(rst_n), .ext_clk_pin(ext_clk_pin), .strobe(strobe),
      .timer_tick(timer_tick), .src_sel(src_sel), .load_en(load_en),
      .load_val(load_val), .ie_wr(ie_wr), .ie_val(ie_val), .flag_clr(flag_clr),
      .count(count), .ovf_flag(ovf_flag), .irq(irq), .carry(carry)
   );

   // Downstream 8-bit stage enabled by carry (R11)
   logic [7:0] upper;
   logic       up_clr;
   always @(posedge clk) begin
      if (up_clr)     upper <= 8'd0;
      else if (carry) upper <= upper + 8'd1;
   end

   typedef struct {
      string      tag;
      logic [3:0] cnt;
      logic       flag;
      logic       irq;
      logic       carry;
   } exp_t;

   exp_t q[$];
   event sample_ev;
   int   n_run  = 0;
   int   n_fail = 0;

   // Monitor: pops expected items and compares them with the ports
   initial begin
      forever begin
         @(sample_ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (count !== e.cnt || ovf_flag !== e.flag || irq !== e.irq || carry !== e.carry) begin
               n_fail++;
               $display("FAIL %s: got cnt=%h flag=%b irq=%b carry=%b, expected cnt=%h flag=%b irq=%b carry=%b",
                        e.tag, count, ovf_flag, irq, carry, e.cnt, e.flag, e.irq, e.carry);
            end
         end
      end
   end

   task automatic expect_now(input string tag, input logic [3:0] c,
                             input logic f, input logic i, input logic k);
      exp_t e;
      e.tag = tag; e.cnt = c; e.flag = f; e.irq = i; e.carry = k;
      q.push_back(e);
      ->sample_ev;
      #0;
   endtask

   task automatic check_val(input string tag, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse_strobe();
      strobe = 1'b1; step(); strobe = 1'b0;
   endtask

   task automatic do_load(input logic [3:0] v);
      load_en = 1'b1; load_val = v; step(); load_en = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; ext_clk_pin = 1'b0; strobe = 1'b0; timer_tick = 1'b0;
      src_sel = 2'b00; load_en = 1'b0; load_val = 4'h0;
      ie_wr = 1'b0; ie_val = 1'b0; flag_clr = 1'b0; up_clr = 1'b1;
      repeat (3) step();
      rst_n = 1'b1; up_clr = 1'b0;
      step();
      expect_now("R1 reset state", 4'h0, 1'b0, 1'b0, 1'b0);

      // R4: strobe advances with no source selected
      repeat (3) pulse_strobe();
      expect_now("R4 three strobes", 4'h3, 1'b0, 1'b0, 1'b0);

      // R5: source off ignores timer and pin
      timer_tick = 1'b1; repeat (4) step(); timer_tick = 1'b0;
      ext_clk_pin = 1'b1; repeat (4) step();
      ext_clk_pin = 1'b0; repeat (4) step();
      expect_now("R5 source off ignores inputs", 4'h3, 1'b0, 1'b0, 1'b0);

      // R3: timer source
      src_sel = 2'b01;
      timer_tick = 1'b1; repeat (5) step(); timer_tick = 1'b0;
      expect_now("R3 five timer ticks", 4'h8, 1'b0, 1'b0, 1'b0);

      // R4: strobe coinciding with a tick adds one
      timer_tick = 1'b1; strobe = 1'b1; step(); timer_tick = 1'b0; strobe = 1'b0;
      expect_now("R4 strobe with tick adds one", 4'h9, 1'b0, 1'b0, 1'b0);

      // R5: timer mode ignores the pin
      ext_clk_pin = 1'b1; repeat (4) step();
      expect_now("R5 pin ignored in timer mode", 4'h9, 1'b0, 1'b0, 1'b0);

      // R2: pin source, falling then rising edge, latency of three edges
      src_sel = 2'b10;
      ext_clk_pin = 1'b0; step(); step();
      expect_now("R2 falling edge not yet counted", 4'h9, 1'b0, 1'b0, 1'b0);
      step();
      expect_now("R2 falling edge counted", 4'hA, 1'b0, 1'b0, 1'b0);
      ext_clk_pin = 1'b1; step(); step();
      expect_now("R2 rising edge not yet counted", 4'hA, 1'b0, 1'b0, 1'b0);
      step();
      expect_now("R2 rising edge counted", 4'hB, 1'b0, 1'b0, 1'b0);

      // R6: wrap
      src_sel = 2'b00;
      do_load(4'hE);
      expect_now("R9 load value", 4'hE, 1'b0, 1'b0, 1'b0);
      pulse_strobe();
      expect_now("R6 at max", 4'hF, 1'b0, 1'b0, 1'b0);
      pulse_strobe();
      expect_now("R6 wrap sets flag and carry", 4'h0, 1'b1, 1'b0, 1'b1);
      step();
      expect_now("R6 carry one cycle, R7 flag held", 4'h0, 1'b1, 1'b0, 1'b0);

      // R8: enable gates irq
      ie_wr = 1'b1; ie_val = 1'b1; step(); ie_wr = 1'b0;
      expect_now("R8 irq after enable", 4'h0, 1'b1, 1'b1, 1'b0);
      flag_clr = 1'b1; step(); flag_clr = 1'b0;
      expect_now("R7 flag cleared", 4'h0, 1'b0, 1'b0, 1'b0);

      // R7: set wins over clear
      do_load(4'hF);
      strobe = 1'b1; flag_clr = 1'b1; step(); strobe = 1'b0; flag_clr = 1'b0;
      expect_now("R7 wrap beats clear", 4'h0, 1'b1, 1'b1, 1'b1);
      flag_clr = 1'b1; step(); flag_clr = 1'b0;

      // R9: load beats strobe, no overflow
      do_load(4'hF);
      load_en = 1'b1; load_val = 4'hF; strobe = 1'b1; step();
      load_en = 1'b0; strobe = 1'b0;
      expect_now("R9 load beats strobe", 4'hF, 1'b0, 1'b0, 1'b0);

      // R10: preset F, one pin edge is an interrupt (pin currently 1)
      src_sel = 2'b10;
      ext_clk_pin = 1'b0; step(); step(); step();
      expect_now("R10 single edge interrupt", 4'h0, 1'b1, 1'b1, 1'b1);

      // R11: 12-bit chain
      flag_clr = 1'b1; step(); flag_clr = 1'b0;
      do_load(4'h0);
      up_clr = 1'b1; step(); up_clr = 1'b0;
      src_sel = 2'b01;
      timer_tick = 1'b1; repeat (40) step(); timer_tick = 1'b0;
      step();
      check_val("R11 chained 12-bit total", {upper, count}, 40);
      check_val("R11 upper stage", upper, 2);

      #1;
      summary();
      $finish;
   end
endmodule